// File: doc/BRIEF.md
# Receive Frame Buffer with Byte-Pop Readout

This block receives Ethernet frames one at a time from a byte stream (valid, ready, last) and holds the current frame in an internal synchronous RAM. Software reads the frame back one byte at a time. Each read of the data port removes one byte: it returns the byte at the read pointer, moves the pointer forward and lowers the pending byte count. The count can be read as a register at any time. A one-cycle pulse tells the interrupt logic that a frame has landed.

A busy flag decides whether a new frame may enter. Software writes this flag, and the block raises it by itself whenever it commits a frame. A frame is stored only if it finishes with a length below the frame limit (1514 bytes by default). A longer frame is still consumed up to its last beat, but nothing from it is kept. After reset a sweep writes zero into every RAM word, and the input stays closed until the sweep is done.

Top module: `rx_frame_buf`

## Requirements
- R1: After reset the busy flag reads 1, the byte count reads 0, the done pulse is low and the stream input is not ready.
- R2: With the sweep enabled, the input ready stays low for DEPTH clock cycles after reset is released, even if software clears busy at once. The sweep writes zero into every buffer word.
- R3: Outside a frame, the input is ready only when busy is 0 and the byte count is below MAX_FRAME. No beat is taken while ready is low.
- R4: A frame whose last beat arrives at a length L below MAX_FRAME is committed. In the cycle after that beat, the count reads L, busy reads 1 and the done pulse is high for exactly one cycle.
- R5: A frame of MAX_FRAME bytes or more is consumed up to its last beat and then discarded. The count, the busy flag and the done pulse do not change, and the input returns to idle.
- R6: A pop while the count is nonzero returns the byte at the read pointer on the data output in the following cycle, and the count drops by one.
- R7: A pop while the count is 0 returns 0 in the following cycle and leaves the count unchanged.
- R8: After each commit the read pointer restarts at byte 0, so successive pops return the frame in arrival order.
- R9: A software busy write takes effect on the next cycle. A commit in the same cycle takes precedence and sets busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | DW | Stream byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block can take a byte |
| busy_wr | input | 1 | Software write strobe for the busy flag |
| busy_val | input | 1 | Value to write into the busy flag |
| busy_o | output | 1 | Current busy flag |
| rx_count | output | CW | Bytes still waiting to be popped |
| pop_req | input | 1 | One-cycle data-register read strobe |
| pop_data | output | DW | Popped byte, valid the cycle after pop_req |
| rxdone_set | output | 1 | One-cycle pulse toward the interrupt logic on commit |

## Verification
The bench aims at the length boundary. A 1513-byte frame must be kept and a 1514-byte frame thrown away; an off-by-one compare would either keep a frame that is too long or lose a legal one. It pops one byte past the end of a frame. A design that does not guard the empty case would underflow the count or return stale RAM data. It also lands a second frame while the first is only partly read. If the pointer were not reset on commit, the pops would return bytes from the middle of the new frame. Finally, it clears busy during the post-reset sweep. A design that opened the input early would take a frame into RAM that is still being cleared.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
   typedef enum logic [1:0] {
      ST_CLEAR = 2'd0,
      ST_IDLE  = 2'd1,
      ST_TAKE  = 2'd2,
      ST_DROP  = 2'd3
   } ing_state_e;
endpackage

// File: rtl/rxb_ram.sv
module rxb_ram #(
   parameter int DW    = 8,
   parameter int DEPTH = 2048
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(DEPTH)-1:0] waddr,
   input  logic [DW-1:0]            wdata,
   input  logic                     re,
   input  logic [$clog2(DEPTH)-1:0] raddr,
   output logic [DW-1:0]            rdata
);
   localparam int AW = $clog2(DEPTH);

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end

   logic unused_aw;
   assign unused_aw = (AW == 0);
endmodule

// File: rtl/rxb_ingress.sv
module rxb_ingress
   import rxb_pkg::*;
#(
   parameter int DW             = 8,
   parameter int DEPTH          = 2048,
   parameter int MAX_FRAME      = 1514,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [DW-1:0]                  in_data,
   input  logic                           in_last,
   input  logic                           can_start,
   output logic                           in_ready,
   output logic                           ram_we,
   output logic [$clog2(DEPTH)-1:0]       ram_waddr,
   output logic [DW-1:0]                  ram_wdata,
   output logic                           commit,
   output logic [$clog2(MAX_FRAME+1)-1:0] commit_len
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(MAX_FRAME + 1);

   ing_state_e    st_q, rst_st;
   logic [AW-1:0] ptr_q;
   logic          beat, too_long;

   if (CLEAR_ON_RESET) begin : g_sweep
      assign rst_st = ST_CLEAR;
   end else begin : g_nosweep
      assign rst_st = ST_IDLE;
   end

   assign in_ready = (st_q == ST_TAKE) || (st_q == ST_DROP) ||
                     ((st_q == ST_IDLE) && can_start);
   assign beat     = in_valid && in_ready;
   assign too_long = (32'(ptr_q) >= 32'(MAX_FRAME - 1));

   assign ram_we     = (st_q == ST_CLEAR) || (beat && (st_q != ST_DROP) && !too_long);
   assign ram_waddr  = ptr_q;
   assign ram_wdata  = (st_q == ST_CLEAR) ? '0 : in_data;
   assign commit     = beat && in_last && (st_q != ST_DROP) && !too_long;
   assign commit_len = CW'(ptr_q) + CW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= rst_st;
         ptr_q <= '0;
      end else begin
         case (st_q)
            ST_CLEAR: begin
               ptr_q <= ptr_q + AW'(1);
               if (ptr_q == AW'(DEPTH - 1)) begin
                  st_q  <= ST_IDLE;
                  ptr_q <= '0;
               end
            end
            ST_IDLE, ST_TAKE: begin
               if (beat) begin
                  if (in_last) begin
                     st_q  <= ST_IDLE;
                     ptr_q <= '0;
                  end else if (too_long) begin
                     st_q  <= ST_DROP;
                     ptr_q <= '0;
                  end else begin
                     st_q  <= ST_TAKE;
                     ptr_q <= ptr_q + AW'(1);
                  end
               end
            end
            ST_DROP: begin
               if (beat && in_last) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxb_drain.sv
module rxb_drain #(
   parameter int DEPTH     = 2048,
   parameter int MAX_FRAME = 1514
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           pop_req,
   input  logic                           commit,
   input  logic [$clog2(MAX_FRAME+1)-1:0] commit_len,
   output logic [$clog2(MAX_FRAME+1)-1:0] count_o,
   output logic                           ram_re,
   output logic [$clog2(DEPTH)-1:0]       ram_raddr,
   output logic                           hit_q
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(MAX_FRAME + 1);

   logic [CW-1:0] count_q;
   logic [AW-1:0] rd_ptr_q;
   logic          hit;

   assign hit       = pop_req && (count_q != '0);
   assign ram_re    = hit;
   assign ram_raddr = rd_ptr_q;
   assign count_o   = count_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q  <= '0;
         rd_ptr_q <= '0;
         hit_q    <= 1'b0;
      end else begin
         hit_q <= hit;
         if (commit) begin
            count_q  <= commit_len;
            rd_ptr_q <= '0;
         end else if (hit) begin
            count_q  <= count_q - CW'(1);
            rd_ptr_q <= rd_ptr_q + AW'(1);
         end
      end
   end
endmodule

// File: rtl/rx_frame_buf.sv
module rx_frame_buf #(
   parameter int DW             = 8,
   parameter int DEPTH          = 2048,
   parameter int MAX_FRAME      = 1514,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           in_valid,
   input  logic [DW-1:0]                  in_data,
   input  logic                           in_last,
   output logic                           in_ready,
   input  logic                           busy_wr,
   input  logic                           busy_val,
   output logic                           busy_o,
   output logic [$clog2(MAX_FRAME+1)-1:0] rx_count,
   input  logic                           pop_req,
   output logic [DW-1:0]                  pop_data,
   output logic                           rxdone_set
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(MAX_FRAME + 1);

   if (DEPTH < MAX_FRAME) begin : g_bad_depth
      $error("rx_frame_buf: DEPTH must be at least MAX_FRAME");
   end
   if (MAX_FRAME < 2) begin : g_bad_max
      $error("rx_frame_buf: MAX_FRAME must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("rx_frame_buf: DW must be positive");
   end

   logic          busy_q, rxdone_q, can_start, commit, hit_q;
   logic          ram_we, ram_re;
   logic [AW-1:0] ram_waddr, ram_raddr;
   logic [DW-1:0] ram_wdata, ram_q;
   logic [CW-1:0] commit_len, count;

   assign can_start = !busy_q && (32'(count) < 32'(MAX_FRAME));

   rxb_ingress #(.DW(DW), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME),
                 .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_ingress (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .can_start(can_start), .in_ready(in_ready),
      .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
      .commit(commit), .commit_len(commit_len));

   rxb_drain #(.DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME)) u_drain (
      .clk(clk), .rst_n(rst_n), .pop_req(pop_req), .commit(commit),
      .commit_len(commit_len), .count_o(count), .ram_re(ram_re),
      .ram_raddr(ram_raddr), .hit_q(hit_q));

   rxb_ram #(.DW(DW), .DEPTH(DEPTH)) u_ram (
      .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
      .re(ram_re), .raddr(ram_raddr), .rdata(ram_q));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b1;
         rxdone_q <= 1'b0;
      end else begin
         rxdone_q <= commit;
         if (commit)       busy_q <= 1'b1;
         else if (busy_wr) busy_q <= busy_val;
      end
   end

   assign busy_o     = busy_q;
   assign rx_count   = count;
   assign rxdone_set = rxdone_q;
   assign pop_data   = hit_q ? ram_q : '0;
endmodule

// File: rtl/rx_frame_buf_chk.sv
module rx_frame_buf_chk #(
   parameter int DW             = 8,
   parameter int DEPTH          = 2048,
   parameter int MAX_FRAME      = 1514,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           in_valid,
   input logic                           in_last,
   input logic                           in_ready,
   input logic                           busy_wr,
   input logic                           busy_val,
   input logic                           busy_o,
   input logic [$clog2(MAX_FRAME+1)-1:0] rx_count,
   input logic                           pop_req,
   input logic [DW-1:0]                  pop_data,
   input logic                           rxdone_set
);
   logic mid_q;
   int   since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mid_q     <= 1'b0;
         since_rst <= 0;
      end else begin
         if (in_valid && in_ready) mid_q <= !in_last;
         if (since_rst < DEPTH) since_rst <= since_rst + 1;
      end
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      32'(rx_count) < 32'(MAX_FRAME));

   a_r2_sweep_closed: assert property (@(posedge clk) disable iff (!rst_n)
      (CLEAR_ON_RESET && since_rst < DEPTH) |-> !in_ready);

   a_r3_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (!mid_q && busy_o) |-> !in_ready);

   a_r4_done_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      rxdone_set |-> busy_o);

   a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rxdone_set |=> !rxdone_set);

   a_r6_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && rx_count != '0) |=> (rxdone_set || rx_count == $past(rx_count) - 1'b1));

   a_r7_empty_pop_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && rx_count == '0) |=> (pop_data == '0 && (rxdone_set || $stable(rx_count))));

   a_r9_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
      busy_wr |=> (rxdone_set || busy_o == $past(busy_val)));
endmodule

bind rx_frame_buf rx_frame_buf_chk #(
   .DW(DW), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME), .CLEAR_ON_RESET(CLEAR_ON_RESET)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
   .in_ready(in_ready), .busy_wr(busy_wr), .busy_val(busy_val), .busy_o(busy_o),
   .rx_count(rx_count), .pop_req(pop_req), .pop_data(pop_data),
   .rxdone_set(rxdone_set)
);

// File: tb/tb_rx_frame_buf.sv
module tb_rx_frame_buf;
   localparam int DW = 8, DEPTH = 2048, MAX_FRAME = 1514;
   localparam int CW = $clog2(MAX_FRAME + 1);

   // columns: frame length, data seed, expected commit (1) or drop (0)
   localparam int VEC_N = 7;
   localparam int VEC [VEC_N][3] = '{
      '{1,    8'h11, 1}, '{60, 8'h20, 1}, '{1514, 8'h30, 0}, '{1513, 8'h41, 1},
      '{1600, 8'h55, 0}, '{2,  8'hFE, 1}, '{64,   8'h07, 1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_last = 1'b0, busy_wr = 1'b0, busy_val = 1'b0, pop_req = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_ready, busy_o, rxdone_set;
   logic [CW-1:0] rx_count;
   logic [DW-1:0] pop_data;

   int checks = 0, failures = 0, done_cnt = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   rx_frame_buf #(.DW(DW), .DEPTH(DEPTH), .MAX_FRAME(MAX_FRAME)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .in_ready(in_ready), .busy_wr(busy_wr),
      .busy_val(busy_val), .busy_o(busy_o), .rx_count(rx_count),
      .pop_req(pop_req), .pop_data(pop_data), .rxdone_set(rxdone_set));

   always @(negedge clk) if (rst_n && rxdone_set) done_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_busy(input logic v);
      @(negedge clk); busy_wr = 1'b1; busy_val = v;
      @(negedge clk); busy_wr = 1'b0;
      chk(busy_o == v, "R9 busy write", int'(busy_o), int'(v));
   endtask

   task automatic send(input int len, input int seed);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_data = DW'(seed + 3 * i); in_last = (i == len - 1);
         while (!in_ready) @(negedge clk);
      end
      @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic pop(output int val);
      pop_req = 1'b1;
      @(negedge clk);
      pop_req = 1'b0;
      val = int'(pop_data);
   endtask

   task automatic summary;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int v, d0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(busy_o == 1'b1, "R1 busy", int'(busy_o), 1);
      chk(rx_count == '0, "R1 count", int'(rx_count), 0);
      chk(rxdone_set == 1'b0, "R1 done", int'(rxdone_set), 0);
      chk(in_ready == 1'b0, "R1 ready", int'(in_ready), 0);

      // R2 sweep keeps input closed even with busy cleared
      set_busy(1'b0);
      repeat (100) @(negedge clk);
      chk(in_ready == 1'b0, "R2 ready during sweep", int'(in_ready), 0);
      repeat (DEPTH) @(negedge clk);
      chk(in_ready == 1'b1, "R2 ready after sweep", int'(in_ready), 1);

      // R7 pop on empty
      @(negedge clk);
      pop(v);
      chk(v == 0, "R7 empty pop data", v, 0);
      chk(rx_count == '0, "R7 empty pop count", int'(rx_count), 0);

      // R3 busy closes input, offered beats are not taken
      set_busy(1'b1);
      chk(in_ready == 1'b0, "R3 ready with busy", int'(in_ready), 0);
      d0 = done_cnt;
      in_valid = 1'b1; in_last = 1'b1; in_data = 8'h99;
      repeat (5) @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      @(negedge clk);
      chk(rx_count == '0, "R3 no beat taken", int'(rx_count), 0);
      chk(done_cnt == d0, "R3 no done", done_cnt - d0, 0);

      // table of frames
      for (int k = 0; k < VEC_N; k++) begin
         int len, seed, exp_commit;
         len = VEC[k][0]; seed = VEC[k][1]; exp_commit = VEC[k][2];
         set_busy(1'b0);
         d0 = done_cnt;
         send(len, seed);
         if (exp_commit != 0) begin
            chk(rxdone_set == 1'b1, "R4 done pulse", int'(rxdone_set), 1);
            chk(int'(rx_count) == len, "R4 count", int'(rx_count), len);
            chk(busy_o == 1'b1, "R4 busy set", int'(busy_o), 1);
            @(negedge clk);
            chk(rxdone_set == 1'b0, "R4 pulse width", int'(rxdone_set), 0);
            for (int i = 0; i < len; i++) begin
               pop(v);
               chk(v == ((seed + 3 * i) & 8'hFF), "R6 R8 pop data", v, (seed + 3 * i) & 8'hFF);
               chk(int'(rx_count) == len - 1 - i, "R6 count", int'(rx_count), len - 1 - i);
            end
            pop(v);
            chk(v == 0, "R7 pop past end", v, 0);
            chk(rx_count == '0, "R7 count stays", int'(rx_count), 0);
         end else begin
            @(negedge clk);
            chk(done_cnt == d0, "R5 no done", done_cnt - d0, 0);
            chk(rx_count == '0, "R5 count unchanged", int'(rx_count), 0);
            chk(busy_o == 1'b0, "R5 busy unchanged", int'(busy_o), 0);
            chk(in_ready == 1'b1, "R5 back to idle", int'(in_ready), 1);
         end
      end

      // R8 new frame while the previous one is partly drained
      set_busy(1'b0);
      send(5, 8'hA0);
      pop(v); pop(v);
      set_busy(1'b0);
      chk(in_ready == 1'b1, "R3 ready with count below limit", int'(in_ready), 1);
      send(3, 8'hC0);
      chk(int'(rx_count) == 3, "R8 count reloaded", int'(rx_count), 3);
      for (int i = 0; i < 3; i++) begin
         pop(v);
         chk(v == ((8'hC0 + 3 * i) & 8'hFF), "R8 restart at byte 0", v, (8'hC0 + 3 * i) & 8'hFF);
      end

      // R1 reset after activity
      set_busy(1'b0);
      send(4, 8'h10);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      chk(rx_count == '0, "R1 count after reset", int'(rx_count), 0);
      chk(busy_o == 1'b1, "R1 busy after reset", int'(busy_o), 1);
      chk(in_ready == 1'b0, "R1 ready after reset", int'(in_ready), 0);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule